// File: doc/BRIEF.md
# Self-Filling Banked Memory with Idle-Bank Gating

This block is a 128-word, 32-bit synchronous memory made of eight banks of sixteen words each. The host never supplies a write address. An internal write pointer steps through the words of one bank and then moves on to the next bank. When the pointer passes the last word of the memory it returns to word zero. Reads carry an explicit address and return their data one cycle later.

Only one bank is enabled in any cycle. A read enables the bank it targets. Otherwise the bank under the write pointer is enabled. Every other bank is reported as gated, and a gated bank keeps its contents. A bank that was gated in the previous cycle cannot take a write yet, so the write is held off with a busy indication until the bank has been enabled for one full cycle. This affects the host in two cases: when the pointer crosses into a new bank, and when a read to another bank has just borrowed the enable.

Top module: `banked_gated_ram`

## Requirements
- R1: Every word written can be read back unchanged at its 7-bit address. The address holds the bank number in bits [6:4] and the word within the bank in bits [3:0], across all eight banks of sixteen words.
- R2: Accepted writes go to successive addresses starting at 0 after reset, and the address after 127 is 0.
- R3: Exactly one bit of `bankEn` is high in every cycle. It selects the bank in `rdAddr[6:4]` when `rdReq` is high, and the bank of the write pointer otherwise.
- R4: `bankGated` is the bitwise complement of `bankEn` in every cycle.
- R5: A write is accepted only when the write pointer's bank was enabled in the previous cycle. If it was not, `wrBusy` is high and the pointer does not move. This includes the first write attempt after the pointer crosses into a new bank.
- R6: When `rdReq` is high, `rdData` holds the addressed word and `rdValid` is high in the next cycle. When `rdReq` is low, `rdValid` drops in the next cycle and `rdData` keeps its value.
- R7: When a read and a write request arrive together and the read targets a bank other than the write pointer's bank, `wrBusy` is high, the write is not performed and the pointer does not advance.
- R8: When a read and an accepted write hit the same address in the same cycle, the read returns the data stored before the write, and a later read returns the new data.
- R9: `full` rises after the 128th accepted write since reset and stays high until reset.
- R10: Synchronous reset returns the pointer to 0, enables only bank 0, and clears `rdData`, `rdValid` and `full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrReq | input | 1 | Write request at the internal pointer |
| wrData | input | 32 | Write data |
| wrBusy | output | 1 | Write request not accepted this cycle |
| rdReq | input | 1 | Read request |
| rdAddr | input | 7 | Read address: bank in [6:4], word in [3:0] |
| rdData | output | 32 | Registered read data |
| rdValid | output | 1 | rdData was loaded by the previous cycle's read |
| bankEn | output | 8 | One-hot enabled bank |
| bankGated | output | 8 | Gated status per bank |
| full | output | 1 | All 128 words have been written since reset |

## Verification
A pointer that skips or repeats a word does not show at once. It appears as wrong data on a later read-back, or as a `full` flag that rises at the wrong write count. Because of that delay, the bench tracks its own pointer and compares on every cycle. A wrong warm-up state, in either direction, shows in the same cycle as an unexpected `wrBusy` or a missing one. This is most visible on the first write after a bank crossing or after a read to another bank. An error in the enable selection shows immediately on `bankEn` and `bankGated`. A read-before-write error shows one cycle later on `rdData`.

// File: rtl/bgr_pkg.sv
package bgr_pkg;
  localparam int DATA_W     = 32;
  localparam int NUM_BANKS  = 8;
  localparam int BANK_WORDS = 16;
  localparam int BANK_W     = $clog2(NUM_BANKS);
  localparam int WORD_W     = $clog2(BANK_WORDS);
  localparam int ADDR_W     = BANK_W + WORD_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 wrEn;
    logic [ADDR_W-1:0]    wrAddr;
    logic                 rdEn;
    logic [ADDR_W-1:0]    rdAddr;
    logic [NUM_BANKS-1:0] bankEn;
  } strobe_t;
endpackage

// File: rtl/bgr_ctrl.sv
module bgr_ctrl
  import bgr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrReq,
  input  logic                 rdReq,
  input  logic [ADDR_W-1:0]    rdAddr,
  output strobe_t              strobes,
  output logic                 wrBusy,
  output logic                 full,
  output logic [NUM_BANKS-1:0] bankEn
);
  logic [ADDR_W-1:0]    wrPtr;
  logic [NUM_BANKS-1:0] prevEn;
  logic [NUM_BANKS-1:0] bankEnC;
  logic [BANK_W-1:0]    wrBank, rdBank, selBank;
  logic                 warm, clash, wrGo;

  assign wrBank  = wrPtr[ADDR_W-1:WORD_W];
  assign rdBank  = rdAddr[ADDR_W-1:WORD_W];
  assign selBank = rdReq ? rdBank : wrBank;

  always_comb begin
    bankEnC = '0;
    bankEnC[selBank] = 1'b1;
  end

  // A bank must have been enabled for a whole cycle before it takes a write
  assign warm  = prevEn[wrBank];
  assign clash = rdReq && (rdBank != wrBank);
  assign wrGo  = wrReq && warm && !clash;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr  <= '0;
      prevEn <= NUM_BANKS'(1);
      full   <= 1'b0;
    end else begin
      prevEn <= bankEnC;
      if (wrGo) begin
        wrPtr <= wrPtr + ADDR_W'(1);
        if (&wrPtr) full <= 1'b1;
      end
    end
  end

  assign wrBusy          = wrReq && !wrGo;
  assign bankEn          = bankEnC;
  assign strobes.wrEn    = wrGo;
  assign strobes.wrAddr  = wrPtr;
  assign strobes.rdEn    = rdReq;
  assign strobes.rdAddr  = rdAddr;
  assign strobes.bankEn  = bankEnC;

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (rst)
    wrGo |=> wrPtr == $past(wrPtr) + ADDR_W'(1));
  p_hold_ptr_r7: assert property (@(posedge clk) disable iff (rst)
    (wrReq && rdReq && rdBank != wrBank) |=> $stable(wrPtr));
  p_clash_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (wrReq && rdReq && rdBank != wrBank) |-> wrBusy);
  p_warm_r5: assert property (@(posedge clk) disable iff (rst)
    wrGo |-> |($past(bankEnC) & (NUM_BANKS'(1) << wrBank)));
  p_full_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    full |=> full);
endmodule

// File: rtl/bgr_dpath.sv
module bgr_dpath
  import bgr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [DATA_W-1:0] bankOut [NUM_BANKS];
  logic [BANK_W-1:0] rdBank;
  logic [BANK_W-1:0] wrBank;

  assign rdBank = strobes.rdAddr[ADDR_W-1:WORD_W];
  assign wrBank = strobes.wrAddr[ADDR_W-1:WORD_W];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    logic [DATA_W-1:0] cells [BANK_WORDS];
    always_ff @(posedge clk) begin
      if (strobes.wrEn && strobes.bankEn[g] && wrBank == BANK_W'(g))
        cells[strobes.wrAddr[WORD_W-1:0]] <= wrData;
    end
    assign bankOut[g] = cells[strobes.rdAddr[WORD_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobes.rdEn;
      if (strobes.rdEn && strobes.bankEn[rdBank])
        rdData <= bankOut[rdBank];
    end
  end

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !strobes.rdEn |=> $stable(rdData));
endmodule

// File: rtl/banked_gated_ram.sv
module banked_gated_ram
  import bgr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrReq,
  input  logic [DATA_W-1:0]    wrData,
  output logic                 wrBusy,
  input  logic                 rdReq,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdValid,
  output logic [NUM_BANKS-1:0] bankEn,
  output logic [NUM_BANKS-1:0] bankGated,
  output logic                 full
);
  strobe_t strobes;

  bgr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrReq(wrReq), .rdReq(rdReq), .rdAddr(rdAddr),
    .strobes(strobes), .wrBusy(wrBusy), .full(full), .bankEn(bankEn)
  );

  bgr_dpath u_dpath (
    .clk(clk), .rst(rst), .strobes(strobes), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid)
  );

  assign bankGated = ~bankEn;

  p_one_bank_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(bankEn) == 1);
  p_rd_valid_r6: assert property (@(posedge clk) disable iff (rst)
    rdReq |=> rdValid);
  p_reset_bank0_r10: assert property (@(posedge clk)
    (rst && !rdReq) |=> (bankEn == NUM_BANKS'(1) || rdReq));
endmodule

// File: tb/sim_banked_gated_ram.sv
`timescale 1ns/1ps
module sim_banked_gated_ram;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrReq = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdReq = 1'b0;
  logic [6:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        rdValid, wrBusy, full;
  logic [7:0]  bankEn, bankGated;

  always #4 clk = ~clk;

  banked_gated_ram u0 (
    .clk(clk), .rst(rst), .wrReq(wrReq), .wrData(wrData), .wrBusy(wrBusy),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid),
    .bankEn(bankEn), .bankGated(bankGated), .full(full)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference
  logic [31:0] mdl [128];
  int          ptr = 0;
  int          lastEn = 0;
  bit          expFull = 0;
  logic [31:0] expRd = '0;
  bit          expVal = 0;
  bit          lastAcc = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    ptr = 0; lastEn = 0; expFull = 0; expRd = '0; expVal = 0;
  endtask

  task automatic step(input bit wr, input logic [31:0] wd, input bit rd, input int ra,
                      input string tag);
    int wb, sel;
    bit busy;
    @(negedge clk);
    chk({tag, " R6 rdData"}, rdData, expRd);
    chk({tag, " R6 rdValid"}, {31'd0, rdValid}, {31'd0, expVal});
    chk({tag, " R9 full"}, {31'd0, full}, {31'd0, expFull});
    wrReq = wr; wrData = wd; rdReq = rd; rdAddr = 7'(ra);
    #1;
    wb = ptr / 16;
    sel = rd ? ra / 16 : wb;
    busy = wr && !(lastEn == wb && !(rd && (ra / 16) != wb));
    chk({tag, " R3 bankEn"}, {24'd0, bankEn}, 32'(8'(1) << sel));
    chk({tag, " R4 bankGated"}, {24'd0, bankGated}, 32'(~(8'(1) << sel)) & 32'hFF);
    chk({tag, " R5/R7 wrBusy"}, {31'd0, wrBusy}, {31'd0, busy});
    if (rd) expRd = mdl[ra];
    expVal = rd;
    lastAcc = wr && !busy;
    if (lastAcc) begin
      mdl[ptr] = wd;
      if (ptr == 127) expFull = 1;
      ptr = (ptr + 1) % 128;
    end
    lastEn = sel;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; wrReq = 0; rdReq = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    modelReset();
  endtask

  task automatic writeOne(input logic [31:0] wd, input string tag);
    int tries = 0;
    do begin
      step(1, wd, 0, 0, tag);
      tries++;
    end while (!lastAcc && tries < 4);
  endtask

  initial begin
    doReset();
    // R10: reset state observed on first cycle
    step(0, 0, 0, 0, "R10 reset");
    // R2 R5: fill crossing from bank 0 into bank 1 stalls once
    for (int i = 0; i < 20; i++) writeOne(32'hA500_0000 + i, "R2 fill");
    // R1 R6: read back across banks, then idle cycles hold data
    step(0, 0, 1, 3, "R1 read");
    step(0, 0, 1, 17, "R1 read");
    step(0, 0, 0, 0, "R6 idle");
    step(0, 0, 0, 0, "R6 idle");
    // R7: read of bank 0 while writing bank 1, then R5 warm-up stall
    step(1, 32'hBEEF_0001, 1, 5, "R7 clash");
    step(1, 32'hBEEF_0001, 0, 0, "R5 warm");
    step(1, 32'hBEEF_0001, 0, 0, "R5 warm");
    // read in same bank as write is no clash
    step(1, 32'hBEEF_0002, 1, 16, "R7 samebank");
    // R9: fill the rest, full only after the 128th
    for (int i = 0; i < 140; i++) begin
      if (ptr == 0 && expFull) break;
      writeOne(32'hC300_0000 + i, "R9 fill");
    end
    // R8: same-address read and write after wrap
    step(1, 32'h1234_5678, 1, 0, "R8 rw");
    step(1, 32'h1234_5678, 1, 0, "R8 rw");
    step(0, 0, 1, 0, "R8 new");
    step(0, 0, 1, 127, "R1 read");
    step(0, 0, 0, 0, "R2 wrap");
    // R10: reset again clears full and pointer
    doReset();
    step(0, 0, 0, 0, "R10 reset2");
    writeOne(32'h0F0F_0F0F, "R2 restart");
    step(0, 0, 1, 0, "R2 restart read");
    step(0, 0, 0, 0, "R2 restart read");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule